// File: doc/BRIEF.md
# Reset release time-out sequencer

This block decides when a chip's internal reset may be lifted after a power-on event, a brown-out event, or a wake-up from sleep. After the power-on or brown-out condition ends, it can run a power-up delay. That delay is counted in pulses of a slow timebase that never stops, because the main oscillator may not be stable yet. In crystal-type oscillator modes, an oscillator settling count of 1024 main clocks follows the delay. Only when the selected counts have finished does the block lower the core hold output.

The external active-low master-clear pin passes through a two-flop synchronizer. The pin only gates the hold output and never stops the timers. A pin held low past the end of the counts therefore lets the core start within the synchronizer latency once the pin is released. A wake-up from sleep in a crystal-type mode reruns only the 1024-clock settling count. The power-up delay is never applied on wake-up. A sticky flag reports that the power-on or brown-out counts have completed.

Top module: `rst_tmo_seq`

## Requirements
- R1: While rst_ni (the power-on pulse) is low, hold_o is 1 and done_o is 0.
- R2: With pwrt_en_i=1 and osc_xtal_i=0, hold_o falls on the clock edge that samples the PWRT_TICKS-th tick_i pulse. Only pulses sampled after the first edge following the power-on release are counted.
- R3: With pwrt_en_i=1 and osc_xtal_i=1, a settling count of OST_CYCLES (1024) clocks starts at the edge where the power-up delay expires. hold_o falls OST_CYCLES edges after that edge.
- R4: With pwrt_en_i=0 and osc_xtal_i=1, hold_o falls OST_CYCLES edges after the first edge following the power-on release.
- R5: With pwrt_en_i=0 and osc_xtal_i=0, there is no time-out. hold_o falls on the third edge after the power-on release, which is the synchronizer latency of the pin.
- R6: While bor_i is high, hold_o is 1 and done_o is 0 from the next edge on. After bor_i falls, the same sequence as in R2 to R4 runs, counted from the first edge that samples bor_i low. With pwrt_en_i=0 and osc_xtal_i=0, hold_o falls on that first edge.
- R7: Whenever the synchronized mclr_ni is low, hold_o is 1, but both counts keep running. If the counts are already done, hold_o falls on the third edge after the pin rises.
- R8: A wake_i pulse sampled with osc_xtal_i=1, while the counts are done and hold_o is 0, raises hold_o at that edge. hold_o falls OST_CYCLES edges later. tick_i is ignored meanwhile, and done_o stays 1.
- R9: A wake_i pulse with osc_xtal_i=0 has no effect: hold_o stays 0.
- R10: done_o becomes 1 when a power-on or brown-out sequence completes. It stays 1 through master-clear and wake-up, and only rst_ni low or bor_i clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main oscillator clock |
| rst_ni | input | 1 | Power-on reset pulse, active low, asynchronous |
| tick_i | input | 1 | One-cycle pulse from the always-running slow timebase |
| bor_i | input | 1 | Brown-out condition, active high, level |
| mclr_ni | input | 1 | External master-clear pin, active low, asynchronous |
| wake_i | input | 1 | Wake-up from sleep event, one-cycle pulse |
| pwrt_en_i | input | 1 | 1 enables the power-up delay |
| osc_xtal_i | input | 1 | 1 = crystal-type oscillator mode, 0 = RC, external or internal clock |
| hold_o | output | 1 | Core hold (internal reset), active high |
| done_o | output | 1 | Power-on or brown-out counts completed (sticky) |

## Verification
The release latency is measured in clock edges from the edge that first samples the ending event, which is the end of power-on, the end of brown-out, a pin release or a wake pulse. The power-up delay expires on the edge that samples the last counted tick, and the settling count adds exactly 1024 edges after that. The pin release adds three edges. The bench drives inputs just after a falling clock edge and sends ticks on fixed edges, so each expected latency is known in advance. A driver task queues that latency, and a monitor counts falling edges from the stimulus until hold_o is seen low, then compares the count.

// File: rtl/rst_tmo_pkg.sv
package rst_tmo_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_PWRT,
    ST_OST,
    ST_RUN,
    ST_WAKE
  } seq_state_e;
endpackage

// File: rtl/rst_tmo_sync.sv
module rst_tmo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rst_tmo_cnt.sv
module rst_tmo_cnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic en_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          last;

  assign last     = (cnt_q == LAST);
  assign expire_o = busy_q & en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && en_i) begin
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rst_tmo_seq.sv
module rst_tmo_seq
  import rst_tmo_pkg::*;
#(
  parameter int PWRT_TICKS  = 72,
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bor_i,
  input  logic mclr_ni,
  input  logic wake_i,
  input  logic pwrt_en_i,
  input  logic osc_xtal_i,
  output logic hold_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic pwrt_start, ost_start;
  logic pwrt_exp, ost_exp;
  logic mclr_s;
  logic hold_q, done_q;

  rst_tmo_sync #(.STAGES(SYNC_STAGES)) u_mclr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mclr_ni),
    .q_o   (mclr_s)
  );

  // power-up delay counts slow-timebase pulses
  rst_tmo_cnt #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pwrt_start),
    .en_i    (tick_i),
    .expire_o(pwrt_exp)
  );

  // oscillator settling counts main clocks
  rst_tmo_cnt #(.LIMIT(OST_CYCLES)) u_ost_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ost_start),
    .en_i    (1'b1),
    .expire_o(ost_exp)
  );

  always_comb begin
    state_d    = state_q;
    pwrt_start = 1'b0;
    ost_start  = 1'b0;
    if (bor_i) begin
      state_d = ST_BOOT;
    end else begin
      unique case (state_q)
        ST_BOOT: begin
          if (pwrt_en_i) begin
            state_d    = ST_PWRT;
            pwrt_start = 1'b1;
          end else if (osc_xtal_i) begin
            state_d   = ST_OST;
            ost_start = 1'b1;
          end else begin
            state_d = ST_RUN;
          end
        end
        ST_PWRT: begin
          if (pwrt_exp) begin
            if (osc_xtal_i) begin
              state_d   = ST_OST;
              ost_start = 1'b1;
            end else begin
              state_d = ST_RUN;
            end
          end
        end
        ST_OST:  if (ost_exp) state_d = ST_RUN;
        ST_RUN: begin
          if (wake_i && osc_xtal_i) begin
            state_d   = ST_WAKE;
            ost_start = 1'b1;
          end
        end
        ST_WAKE: if (ost_exp) state_d = ST_RUN;
        default: state_d = ST_BOOT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      hold_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= bor_i | (state_d != ST_RUN) | ~mclr_s;
      if (bor_i)                  done_q <= 1'b0;
      else if (state_d == ST_RUN) done_q <= 1'b1;
    end
  end

  assign hold_o = hold_q;
  assign done_o = done_q;
endmodule

// File: rtl/rst_tmo_seq_chk.sv
module rst_tmo_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bor_i,
  input logic mclr_ni,
  input logic wake_i,
  input logic osc_xtal_i,
  input logic hold_o,
  input logic done_o
);
  // R1
  hold_while_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> hold_o);

  // R6
  bor_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bor_i |=> (hold_o && !done_o));

  // R7
  pin_low_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclr_ni |=> ##2 hold_o);

  // R8
  wake_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && osc_xtal_i && done_o && !hold_o && !bor_i) |=> (hold_o && done_o));

  // R10
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !bor_i) |=> done_o);
endmodule

bind rst_tmo_seq rst_tmo_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bor_i     (bor_i),
  .mclr_ni   (mclr_ni),
  .wake_i    (wake_i),
  .osc_xtal_i(osc_xtal_i),
  .hold_o    (hold_o),
  .done_o    (done_o)
);

// File: tb/rst_tmo_seq_tb_top.sv
module rst_tmo_seq_tb_top;
  localparam int TB_TICKS = 3;
  localparam int TB_OST   = 1024;
  localparam int GAP      = 5;
  localparam int PWRT_LAT = 1 + TB_TICKS * GAP;

  typedef struct {
    string req;
    int    lat;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, bor = 1'b0, mclr_n = 1'b1, wake = 1'b0;
  logic pwrt_en = 1'b1, xtal = 1'b0;
  logic hold, done;

  int   errors = 0, checks = 0;
  exp_t exp_q[$];
  bit   armed = 1'b0;
  int   n = 0;

  always #2 clk = ~clk;

  rst_tmo_seq #(.PWRT_TICKS(TB_TICKS), .OST_CYCLES(TB_OST)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .bor_i     (bor),
    .mclr_ni   (mclr_n),
    .wake_i    (wake),
    .pwrt_en_i (pwrt_en),
    .osc_xtal_i(xtal),
    .hold_o    (hold),
    .done_o    (done)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: counts falling edges from stimulus until hold_o drops
  always @(negedge clk) begin
    if (armed) begin
      exp_t item;
      n++;
      if (!hold) begin
        item = exp_q.pop_front();
        check(item.req, n, item.lat);
        armed = 1'b0;
      end else if (n > 4000) begin
        item = exp_q.pop_front();
        check(item.req, n, item.lat);
        armed = 1'b0;
      end
    end
  end

  task automatic arm(input string req, input int lat);
    exp_t e;
    e.req = req;
    e.lat = lat;
    exp_q.push_back(e);
    n = 0;
    armed = 1'b1;
  endtask

  // tick sampled on edges 1+j*GAP after the release edge
  task automatic send_ticks();
    for (int k = 1; k <= TB_TICKS * GAP; k++) begin
      @(negedge clk); #1 tick = (k % GAP == 0);
    end
    @(negedge clk); #1 tick = 1'b0;
  endtask

  task automatic por_case(input string req, input bit p, input bit x, input int lat);
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 pwrt_en = p; xtal = x;
    @(negedge clk); #1 rst_n = 1'b1;
    arm(req, lat);
    if (p) send_ticks();
    wait (!armed);
  endtask

  task automatic bor_case(input string req, input bit p, input bit x, input int lat);
    @(negedge clk); #1 bor = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 hold during brown-out", int'(hold), 1);
    check("R6 done cleared by brown-out", int'(done), 0);
    #1 pwrt_en = p; xtal = x;
    @(negedge clk); #1 bor = 1'b0;
    arm(req, lat);
    if (p) send_ticks();
    wait (!armed);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 hold in reset", int'(hold), 1);
    check("R1 done in reset", int'(done), 0);

    por_case("R2 timer only", 1'b1, 1'b0, PWRT_LAT);
    check("R10 done after sequence", int'(done), 1);
    por_case("R3 timer plus settle", 1'b1, 1'b1, PWRT_LAT + TB_OST);
    por_case("R4 settle only", 1'b0, 1'b1, 1 + TB_OST);
    por_case("R5 no time-out", 1'b0, 1'b0, 3);

    bor_case("R6 brown-out timer", 1'b1, 1'b0, PWRT_LAT);
    bor_case("R6 brown-out none", 1'b0, 1'b0, 1);
    bor_case("R6 brown-out settle", 1'b0, 1'b1, 1 + TB_OST);
    check("R10 done after brown-out", int'(done), 1);

    // R7: pin held low through the whole sequence
    @(negedge clk); #1 rst_n = 1'b0; mclr_n = 1'b0; pwrt_en = 1'b1; xtal = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    send_ticks();
    repeat (1100) @(negedge clk);
    check("R7 hold while pin low", int'(hold), 1);
    check("R10 done while pin low", int'(done), 1);
    #1 mclr_n = 1'b1;
    arm("R7 release after pin high", 3);
    wait (!armed);

    // R8: wake in crystal mode
    @(negedge clk); #1 wake = 1'b1;
    arm("R8 wake settle", 1 + TB_OST);
    @(negedge clk);
    check("R8 hold at wake edge", int'(hold), 1);
    #1 wake = 1'b0;
    send_ticks();
    wait (!armed);
    check("R8 done kept through wake", int'(done), 1);

    // R9: wake in non-crystal mode ignored
    @(negedge clk); #1 xtal = 1'b0; wake = 1'b1;
    @(negedge clk); #1 wake = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 wake ignored", int'(hold), 0);
    end
    check("R10 done after ignored wake", int'(done), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule